// File: doc/BRIEF.md
# Dual Blink Generator with Per-Pin Output Routing

This block creates two independent blink waveforms from a shared time-base tick and routes one of four sources to each of eight open-drain style pins. Each blink channel has an 8-bit prescaler and an 8-bit duty threshold. A duty counter advances once for every prescaler-plus-one ticks. With a tick rate of 38 times 256 per second, the channel period is (prescaler + 1) / 38 seconds, which spans roughly 6.7 s down to 26 ms.

Each pin has a 2-bit route field. The field either drives the pin low, releases it to the external pull-up, or makes it follow blink channel 0 or blink channel 1. A released pin can serve as an input. The block samples the live level on every pin into a readable pin-state register. Changes to a channel's prescaler or duty threshold are held back until that channel's duty counter wraps, so a running blink never shows a partial period.

Configuration uses a simple synchronous write port and a combinational read port, both addressed by a 3-bit register index.

Top module: `led_blink_router`

## Requirements
- R1: After a synchronous active-low reset, every route field holds code 01 (released), no pin is driven low, all pins read high, the pin-state register holds FFh, and the prescaler and duty registers read 00h.
- R2: Register index 0 holds the channel-0 prescaler, 1 the channel-0 duty, 2 the channel-1 prescaler and 3 the channel-1 duty. Index 4 holds the route fields of pins 0 to 3 and index 5 those of pins 4 to 7, with pin p at bits 2*(p%4)+1:2*(p%4). Index 6 reads the pin-state register. Writes to 6 and 7 change nothing, and index 7 reads 00h.
- R3: A channel's duty counter advances by one, wrapping from 255 to 0, on every (prescaler+1)-th cycle with the tick input high. It never moves in a cycle with the tick input low.
- R4: A blink channel is high only while its duty count is strictly greater than its active duty threshold. An active threshold of 00h keeps the channel low all the time.
- R5: New prescaler and duty values become active only in the cycle where that channel's duty counter wraps from 255 to 0. Until then, the channel keeps the previous values.
- R6: Route code 00 drives the pin low. Code 01 releases it. Code 10 drives it low exactly when channel 0 is low, and code 11 does the same for channel 1. The drive-low output is registered one cycle after the route field and the blink level.
- R7: Each pin level output is low when the block drives that pin low or when the external pull-down input for that pin is high. Otherwise the pin level is high.
- R8: The pin-state register captures all eight pin levels every cycle, so it shows the pin levels of the previous cycle.
- R9: The two channels run independently: programming or ticking one channel does not change the other channel's counter or blink output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Time-base tick enable, one pulse per base step |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register index for writes |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Register index for reads |
| rd_data_o | output | 8 | Read data, combinational |
| ext_low_i | input | 8 | External pull-down per pin (pin used as input) |
| drive_low_o | output | 8 | Per-pin open-drain drive-low enable |
| pin_o | output | 8 | Resolved pin level |
| pin_state_o | output | 8 | Pin-state register |

## Verification
The bench targets the wrap boundary of each duty counter. Duty writes are placed mid-period, and a design that applied them at once would switch a pin's blink edge early. It also covers a zero duty threshold, which must keep the pin driven low and not show a one-count high glitch at count 0. Tick-gapped runs with a nonzero prescaler catch a counter that steps on every clock or that miscounts the prescaler by one. Writes to the read-only and unused register indices, together with external pull-downs on released pins, catch a design that corrupts the configuration or reports driven rather than actual pin levels.

// File: rtl/blink_pkg.sv
// Package: shared widths, route codes and register indices for the
// dual blink generator. Assumes an 8-bit register file with 3-bit index.
package blink_pkg;

    localparam int REG_W   = 8;   // register and counter width
    localparam int IDX_W   = 3;   // register index width
    localparam int ROUTE_W = 2;   // route field width per pin

    // Route codes for one pin
    typedef enum logic [ROUTE_W-1:0] {
        ROUTE_LOW  = 2'b00,
        ROUTE_OFF  = 2'b01,
        ROUTE_BLK0 = 2'b10,
        ROUTE_BLK1 = 2'b11
    } route_e;

    // Register indices
    localparam logic [IDX_W-1:0] IDX_PRE0   = 3'd0;
    localparam logic [IDX_W-1:0] IDX_DUTY0  = 3'd1;
    localparam logic [IDX_W-1:0] IDX_PRE1   = 3'd2;
    localparam logic [IDX_W-1:0] IDX_DUTY1  = 3'd3;
    localparam logic [IDX_W-1:0] IDX_ROUTE0 = 3'd4;
    localparam logic [IDX_W-1:0] IDX_ROUTE1 = 3'd5;
    localparam logic [IDX_W-1:0] IDX_PINS   = 3'd6;

endpackage

// File: rtl/blink_channel.sv
// Module: blink_channel
// One blink generator. A prescaler counts ticks up to the active prescale
// value and then steps the duty counter. The blink level is high while the
// duty count is above the active threshold, and a zero threshold forces it
// low. The programmed prescale and threshold values are copied into the
// active set only when the duty counter wraps.
// Assumes: tick_i is a single-cycle enable and the programmed values are
// stable register outputs.
module blink_channel #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] pre_prog_i,
    input  logic [CNT_W-1:0] duty_prog_i,
    output logic             blink_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] pre_q;
    logic [CNT_W-1:0] duty_q;
    logic [CNT_W-1:0] pre_act_q;
    logic [CNT_W-1:0] duty_act_q;
    logic             pre_hit;
    logic             wrap;

    // Prescaler terminal count and duty counter wrap detection
    always_comb begin
        pre_hit = tick_i && (pre_q == pre_act_q);
        wrap    = pre_hit && (duty_q == CNT_MAX);
    end

    // Prescaler: count ticks, restart at the active prescale value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (pre_hit) begin
            pre_q <= '0;
        end else if (tick_i) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // Duty counter: one step per prescaler terminal count, natural wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_q <= '0;
        end else if (pre_hit) begin
            duty_q <= duty_q + 1'b1;
        end
    end

    // Active settings: take programmed values only at the duty wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_act_q  <= '0;
            duty_act_q <= '0;
        end else if (wrap) begin
            pre_act_q  <= pre_prog_i;
            duty_act_q <= duty_prog_i;
        end
    end

    // Blink level from duty compare, zero threshold holds it low
    always_comb begin
        blink_o = (duty_act_q != '0) && (duty_q > duty_act_q);
    end

    // R3
    pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= pre_act_q);

    // R3
    duty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(duty_q));

    // R5
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_i && (duty_q == CNT_MAX) && (pre_q == pre_act_q))
        |=> ($stable(duty_act_q) && $stable(pre_act_q)));

endmodule

// File: rtl/blink_regfile.sv
// Module: blink_regfile
// Configuration storage: a prescale and a threshold per channel and a route
// field per pin, with a combinational read port that also returns the
// pin-state register. Index 6 is read-only and index 7 is unused.
// Assumes NUM_CH <= 2 and NUM_PINS fits in two route bytes.
module blink_regfile
    import blink_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int NUM_PINS = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en_i,
    input  logic [IDX_W-1:0]                  wr_addr_i,
    input  logic [REG_W-1:0]                  wr_data_i,
    input  logic [IDX_W-1:0]                  rd_addr_i,
    input  logic [NUM_PINS-1:0]               pin_state_i,
    output logic [REG_W-1:0]                  rd_data_o,
    output logic [NUM_CH-1:0][REG_W-1:0]      pre_o,
    output logic [NUM_CH-1:0][REG_W-1:0]      duty_o,
    output logic [NUM_PINS-1:0][ROUTE_W-1:0]  route_o
);

    localparam int PINS_PER_REG = REG_W / ROUTE_W;

    logic [NUM_CH-1:0][REG_W-1:0]     pre_q;
    logic [NUM_CH-1:0][REG_W-1:0]     duty_q;
    logic [NUM_PINS-1:0][ROUTE_W-1:0] route_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [IDX_W-1:0] PRE_IDX  = IDX_W'(2 * c);
        localparam logic [IDX_W-1:0] DUTY_IDX = IDX_W'(2 * c + 1);

        // Channel settings: capture on matching write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pre_q[c]  <= '0;
                duty_q[c] <= '0;
            end else if (wr_en_i) begin
                if (wr_addr_i == PRE_IDX)  pre_q[c]  <= wr_data_i;
                if (wr_addr_i == DUTY_IDX) duty_q[c] <= wr_data_i;
            end
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam logic [IDX_W-1:0] ROUTE_IDX = IDX_ROUTE0 + IDX_W'(p / PINS_PER_REG);
        localparam int               LSB       = (p % PINS_PER_REG) * ROUTE_W;

        // Route field: released after reset, capture its slice on write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                route_q[p] <= ROUTE_OFF;
            end else if (wr_en_i && (wr_addr_i == ROUTE_IDX)) begin
                route_q[p] <= wr_data_i[LSB +: ROUTE_W];
            end
        end
    end

    // Read mux over all indices
    always_comb begin
        rd_data_o = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_addr_i == IDX_W'(2 * c))     rd_data_o = pre_q[c];
            if (rd_addr_i == IDX_W'(2 * c + 1)) rd_data_o = duty_q[c];
        end
        for (int p = 0; p < NUM_PINS; p++) begin
            if (rd_addr_i == IDX_ROUTE0 + IDX_W'(p / PINS_PER_REG)) begin
                rd_data_o[(p % PINS_PER_REG) * ROUTE_W +: ROUTE_W] = route_q[p];
            end
        end
        if (rd_addr_i == IDX_PINS) rd_data_o = REG_W'(pin_state_i);
    end

    assign pre_o   = pre_q;
    assign duty_o  = duty_q;
    assign route_o = route_q;

    // R2
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wr_addr_i >= IDX_PINS))
        |=> ($stable(pre_q) && $stable(duty_q) && $stable(route_q)));

endmodule

// File: rtl/pin_router.sv
// Module: pin_router
// Per-pin source selection and open-drain model. Each pin's drive-low enable
// is registered from its route field and the blink levels. The pin level is
// low if the block or an external device pulls it low. A pin-state register
// captures all pin levels every cycle.
// Assumes a blink level of 1 means the pin is released.
module pin_router
    import blink_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int NUM_PINS = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_PINS-1:0][ROUTE_W-1:0] route_i,
    input  logic [NUM_CH-1:0]                blink_i,
    input  logic [NUM_PINS-1:0]              ext_low_i,
    output logic [NUM_PINS-1:0]              drive_low_o,
    output logic [NUM_PINS-1:0]              pin_o,
    output logic [NUM_PINS-1:0]              pin_state_o
);

    logic [NUM_PINS-1:0] drive_q;
    logic [NUM_PINS-1:0] state_q;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic drive_d;

        // Decode the route field into a drive-low request
        always_comb begin
            unique case (route_e'(route_i[p]))
                ROUTE_LOW:  drive_d = 1'b1;
                ROUTE_OFF:  drive_d = 1'b0;
                ROUTE_BLK0: drive_d = !blink_i[0];
                ROUTE_BLK1: drive_d = !blink_i[NUM_CH - 1];
                default:    drive_d = 1'b0;
            endcase
        end

        // Register the drive-low request, released after reset
        always_ff @(posedge clk) begin
            if (!rst_n) drive_q[p] <= 1'b0;
            else        drive_q[p] <= drive_d;
        end

        // R6
        off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (route_i[p] == ROUTE_OFF) |=> !drive_low_o[p]);

        // R6
        low_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (route_i[p] == ROUTE_LOW) |=> drive_low_o[p]);
    end

    // Wired-AND pin level of block and external pull-downs
    always_comb begin
        pin_o = ~(drive_q | ext_low_i);
    end

    // Pin-state register: sample the pin levels every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '1;
        else        state_q <= pin_o;
    end

    assign drive_low_o = drive_q;
    assign pin_state_o = state_q;

    // R8
    pin_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pin_state_o == $past(pin_o)));

    // R7
    ext_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ext_low_i & pin_o) == '0));

endmodule

// File: rtl/led_blink_router.sv
// Module: led_blink_router (top)
// Two blink channels fed by a shared tick, a register file for their
// settings and the per-pin route fields, and a pin router with pin-state
// readback.
// Assumes the tick_i rate is set outside the block (38 * 256 per second for
// the nominal period of (prescale + 1) / 38 seconds).
module led_blink_router
    import blink_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic                wr_en_i,
    input  logic [IDX_W-1:0]    wr_addr_i,
    input  logic [REG_W-1:0]    wr_data_i,
    input  logic [IDX_W-1:0]    rd_addr_i,
    output logic [REG_W-1:0]    rd_data_o,
    input  logic [NUM_PINS-1:0] ext_low_i,
    output logic [NUM_PINS-1:0] drive_low_o,
    output logic [NUM_PINS-1:0] pin_o,
    output logic [NUM_PINS-1:0] pin_state_o
);

    logic [NUM_CH-1:0][REG_W-1:0]     pre_w;
    logic [NUM_CH-1:0][REG_W-1:0]     duty_w;
    logic [NUM_PINS-1:0][ROUTE_W-1:0] route_w;
    logic [NUM_CH-1:0]                blink_w;

    blink_regfile #(
        .NUM_CH   (NUM_CH),
        .NUM_PINS (NUM_PINS)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .rd_addr_i   (rd_addr_i),
        .pin_state_i (pin_state_o),
        .rd_data_o   (rd_data_o),
        .pre_o       (pre_w),
        .duty_o      (duty_w),
        .route_o     (route_w)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        blink_channel #(
            .CNT_W (REG_W)
        ) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick_i      (tick_i),
            .pre_prog_i  (pre_w[c]),
            .duty_prog_i (duty_w[c]),
            .blink_o     (blink_w[c])
        );
    end

    pin_router #(
        .NUM_CH   (NUM_CH),
        .NUM_PINS (NUM_PINS)
    ) u_pins (
        .clk         (clk),
        .rst_n       (rst_n),
        .route_i     (route_w),
        .blink_i     (blink_w),
        .ext_low_i   (ext_low_i),
        .drive_low_o (drive_low_o),
        .pin_o       (pin_o),
        .pin_state_o (pin_state_o)
    );

endmodule

// File: tb/sim_led_blink_router.sv
module sim_led_blink_router;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [2:0] wr_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic [2:0] rd_addr_i = '0;
    logic [7:0] ext_low_i = '0;
    logic [7:0] rd_data_o, drive_low_o, pin_o, pin_state_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    string cur_tag = "R6";

    // Bench model state
    logic [7:0] m_pre [2], m_duty [2], m_pcnt [2], m_cnt [2], m_apre [2], m_aduty [2];
    logic [1:0] m_route [8];
    logic [7:0] m_drv, m_in;

    always #(CLK_PERIOD/2) clk = ~clk;

    led_blink_router u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o), .ext_low_i(ext_low_i), .drive_low_o(drive_low_o),
        .pin_o(pin_o), .pin_state_o(pin_state_o)
    );

    function automatic bit exp_blink(int c);
        return (m_aduty[c] != 8'd0) && (m_cnt[c] > m_aduty[c]);
    endfunction

    function automatic logic [7:0] exp_rd(logic [2:0] a);
        case (a)
            3'd0: return m_pre[0];
            3'd1: return m_duty[0];
            3'd2: return m_pre[1];
            3'd3: return m_duty[1];
            3'd4: return {m_route[3], m_route[2], m_route[1], m_route[0]};
            3'd5: return {m_route[7], m_route[6], m_route[5], m_route[4]};
            3'd6: return m_in;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_pre[c] = 0; m_duty[c] = 0; m_pcnt[c] = 0; m_cnt[c] = 0;
            m_apre[c] = 0; m_aduty[c] = 0;
        end
        for (int p = 0; p < 8; p++) m_route[p] = 2'b01;
        m_drv = 8'h00;
        m_in  = 8'hFF;
    endtask

    // One clock edge of the model, using inputs and state before the edge
    task automatic model_step();
        logic [7:0] nd, nin;
        logic b0, b1;
        b0 = exp_blink(0);
        b1 = exp_blink(1);
        for (int p = 0; p < 8; p++) begin
            case (m_route[p])
                2'b00: nd[p] = 1'b1;
                2'b01: nd[p] = 1'b0;
                2'b10: nd[p] = !b0;
                default: nd[p] = !b1;
            endcase
        end
        nin = ~(m_drv | ext_low_i);
        if (tick_i) begin
            for (int c = 0; c < 2; c++) begin
                if (m_pcnt[c] == m_apre[c]) begin
                    m_pcnt[c] = 0;
                    if (m_cnt[c] == 8'd255) begin
                        m_cnt[c]   = 0;
                        m_apre[c]  = m_pre[c];
                        m_aduty[c] = m_duty[c];
                    end else begin
                        m_cnt[c] = m_cnt[c] + 1;
                    end
                end else begin
                    m_pcnt[c] = m_pcnt[c] + 1;
                end
            end
        end
        if (wr_en_i) begin
            case (wr_addr_i)
                3'd0: m_pre[0]  = wr_data_i;
                3'd1: m_duty[0] = wr_data_i;
                3'd2: m_pre[1]  = wr_data_i;
                3'd3: m_duty[1] = wr_data_i;
                3'd4: for (int p = 0; p < 4; p++) m_route[p]     = wr_data_i[2*p +: 2];
                3'd5: for (int p = 0; p < 4; p++) m_route[p + 4] = wr_data_i[2*p +: 2];
                default: ;
            endcase
        end
        m_drv = nd;
        m_in  = nin;
    endtask

    task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check(cur_tag, "drive_low", drive_low_o, m_drv);
        check("R7", "pin", pin_o, ~(m_drv | ext_low_i));
        check("R8", "pin_state", pin_state_o, m_in);
        check("R2", "rd_data", rd_data_o, exp_rd(rd_addr_i));
    endtask

    // Advance one cycle: edge, model update, compare away from the edge
    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic write_reg(logic [2:0] a, logic [7:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        cycle();
        wr_en_i = 1'b0;
    endtask

    task automatic run(int n, int tick_every);
        for (int i = 0; i < n; i++) begin
            tick_i = (i % tick_every) == 0;
            rd_addr_i = 3'(i % 8);
            cycle();
        end
        tick_i = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state while reset is still applied
        check("R1", "drive_low reset", drive_low_o, 8'h00);
        check("R1", "pin reset", pin_o, 8'hFF);
        check("R1", "pin_state reset", pin_state_o, 8'hFF);
        rd_addr_i = 3'd4;
        #1 check("R1", "route reset", rd_data_o, 8'h55);
        rd_addr_i = 3'd0;
        #1 check("R1", "pre0 reset", rd_data_o, 8'h00);
        rst_n = 1'b1;

        // R4: blink high above threshold, zero threshold holds channel low
        cur_tag = "R4";
        write_reg(3'd0, 8'd0);
        write_reg(3'd1, 8'd128);
        write_reg(3'd2, 8'd1);
        write_reg(3'd3, 8'd0);
        write_reg(3'd4, 8'hAA);
        write_reg(3'd5, 8'hFF);
        run(1200, 1);

        // R5: mid-period change only takes effect at the wrap
        cur_tag = "R5";
        run(100, 1);
        write_reg(3'd1, 8'd20);
        write_reg(3'd3, 8'd250);
        run(900, 1);

        // R3: gapped ticks with a nonzero prescaler
        cur_tag = "R3";
        write_reg(3'd0, 8'd2);
        run(4000, 3);

        // R9: channels programmed differently, one channel touched mid-run
        cur_tag = "R9";
        write_reg(3'd2, 8'd0);
        write_reg(3'd3, 8'd60);
        write_reg(3'd5, 8'h5B);
        run(1500, 1);
        write_reg(3'd1, 8'd200);
        run(1500, 1);

        // R2: read-only and unused indices ignore writes
        cur_tag = "R6";
        write_reg(3'd6, 8'h3C);
        write_reg(3'd7, 8'hC3);
        for (int a = 0; a < 8; a++) begin
            rd_addr_i = 3'(a);
            cycle();
        end

        // R7: released pins pulled low externally, R6 static codes
        write_reg(3'd4, 8'h55);
        write_reg(3'd5, 8'h50);
        for (int i = 0; i < 40; i++) begin
            ext_low_i = 8'($urandom);
            cycle();
        end
        ext_low_i = 8'h00;

        // Random mix of writes, ticks, reads and external pulls
        for (int i = 0; i < 20000; i++) begin
            tick_i    = ($urandom % 2) == 0;
            rd_addr_i = 3'($urandom % 8);
            ext_low_i = (($urandom % 8) == 0) ? 8'($urandom) : 8'h00;
            if (($urandom % 10) == 0) begin
                wr_en_i   = 1'b1;
                wr_addr_i = 3'($urandom % 8);
                wr_data_i = 8'($urandom);
                if (wr_addr_i == 3'd0 || wr_addr_i == 3'd2) wr_data_i = wr_data_i & 8'h03;
            end
            cycle();
            wr_en_i = 1'b0;
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule